// File: doc/BRIEF.md
# Sixty-Four Input Interrupt Concentrator

This block gathers 64 interrupt inputs into one request line for a processor and sits behind an APB slave port. Each input has an enable bit. The low and high halves of every per-source field sit in separate 32-bit words: sources 31..0 are in the low word and sources 63..32 are in the high word. A control register holds a master enable. No request reaches the processor while the master enable is clear.

A parameter sets each input as level or pulse. A level input is seen through its synchronized state. A pulse input is latched into a capture flag on its rising edge. The flag stays set until software clears it by writing a zero to that bit. The pending words show the enabled active sources. Software polls them and services bits from the lowest upward until both words read zero.

A table of 64 byte-wide slots records, for each priority channel, the source that feeds it. Software can read and write the whole table. After reset it holds a fixed default arrangement.

Top module: `irq_hub64`

## Requirements
- R1: Reset (presetn low at a clock edge) clears the control word, both enable words and all capture flags, and drives cpu_irq low. While reset is held, cpu_irq stays low.
- R2: The enable words at offset 0x10 (sources 31..0) and 0x28 (sources 63..32) store and read back all 32 bits.
- R3: In the control word at offset 0x00, bit 31 is the master enable and every other bit reads 0. While the master enable is clear, cpu_irq is low in the cycle after the clear takes effect.
- R4: A rising edge on a pulse source sets that source's capture flag, whether or not the source is enabled. The flag stays set after the input falls. With the default PULSE_MASK, sources 63..32 are pulse sources and sources 31..0 are level sources. The flag words are at offset 0x08 (low) and 0x20 (high). Bits for level sources read 0.
- R5: A write to a flag word clears each flag whose write-data bit is 0 and leaves each flag whose bit is 1 unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R6: The channel table occupies offsets 0x40 to 0x7C. Each word holds four byte slots and can be read and written. After reset, the word at 0x40+4w reads {4w, 4w+1, 4w+2, 4w+3} from byte lane 3 down to lane 0 (0x00010203 at 0x40).
- R7: The pending words at offset 0x14 (low) and 0x2C (high) read the enable bits ANDed with each source's state. The state is the capture flag for a pulse source and the two-flop synchronized level for a level source. Writes to the pending words have no effect.
- R8: A pending bit reads 0 in the first access after its flag is cleared, after its enable is cleared, or (for a level source) once the input low has passed the synchronizer.
- R9: cpu_irq is a register loaded with the master enable ANDed with the OR of all pending bits. A level input held high with its enable and the master enable set raises cpu_irq three clock edges after the input changes.
- R10: A read from an unmapped offset returns zero, and a write to one has no effect. Offsets that are not multiples of 4 count as unmapped. pready is always 1 and pslverr always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always 0 |
| src_in | input | 64 | Interrupt inputs |
| cpu_irq | output | 1 | Request to the processor |

## Verification
The assertions assume the bus master follows the APB two-phase protocol and changes paddr and pwdata only between transfers. The flag-clear check also assumes flags change only through the bus or through a detected edge. The bench drives every transfer as a setup cycle followed by one access cycle, and holds address and data steady across both. Input pulses are at least one full clock period wide, so the synchronizer always captures them. Every input change is made on the falling clock edge.

// File: rtl/irq_hub_pkg.sv
// Package: shared constants for the interrupt concentrator.
// Assumes 64 sources split into two 32-bit words, and byte addressing.
package irq_hub_pkg;
    localparam int NUM_SRC   = 64;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_SRC / WORD_W;
    localparam int TBL_WORDS = NUM_SRC / 4;
    localparam int TBL_IDX_W = $clog2(TBL_WORDS);

    // Register byte offsets.
    localparam logic [11:0] OFF_CTRL    = 12'h000;
    localparam logic [11:0] OFF_FLAG_LO = 12'h008;
    localparam logic [11:0] OFF_EN_LO   = 12'h010;
    localparam logic [11:0] OFF_PEND_LO = 12'h014;
    localparam logic [11:0] OFF_FLAG_HI = 12'h020;
    localparam logic [11:0] OFF_EN_HI   = 12'h028;
    localparam logic [11:0] OFF_PEND_HI = 12'h02C;
    localparam logic [11:0] OFF_TBL     = 12'h040;

    localparam int MASTER_BIT = 31;
endpackage

// File: rtl/irq_src_stage.sv
// Source stage: synchronizes every input through two flops. Pulse sources
// get a rising-edge detector and a capture flag; level sources pass the
// synchronized level straight through. Assumes clr_keep is only meaningful
// while clr_we is high.
module irq_src_stage #(
    parameter int                  NUM_SRC    = 64,
    parameter logic [NUM_SRC-1:0]  PULSE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_keep,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] src_state
);
    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] rise_w;

    // Two-flop synchronizer for all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (PULSE_MASK[i]) begin : g_pulse
            logic prev_q;
            logic cap_q;
            assign rise_w[i] = sync_q[i] & ~prev_q;
            // Edge history and capture flag; a new edge wins over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    cap_q  <= 1'b0;
                end else begin
                    prev_q <= sync_q[i];
                    cap_q  <= (clr_we ? (cap_q & clr_keep[i]) : cap_q) | rise_w[i];
                end
            end
            assign flag_q[i]    = cap_q;
            assign src_state[i] = cap_q;
        end else begin : g_level
            assign rise_w[i]    = 1'b0;
            assign flag_q[i]    = 1'b0;
            assign src_state[i] = sync_q[i];
        end
    end

    // A flag may only rise after an edge was detected.
    assert_flag_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q & ~$past(flag_q) & ~$past(rise_w)) == '0);

    // A flag may only fall after a clearing write with a 0 in that bit.
    assert_flag_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) & ~flag_q & ~($past(clr_we) ? ~$past(clr_keep) : '0)) == '0);
endmodule

// File: rtl/irq_chan_table.sv
// Channel table: TBL_WORDS words of four byte slots each, one slot per
// channel. Reset loads slot values in descending lane order. Assumes a
// single write port and an independent combinational read port.
module irq_chan_table #(
    parameter int WORDS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rdata
);
    logic [31:0] words_q [WORDS];

    function automatic logic [31:0] rst_word(input int w);
        logic [7:0] base;
        base = 8'(4 * w);
        return {base, base + 8'd1, base + 8'd2, base + 8'd3};
    endfunction

    // Table storage with computed reset contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) words_q[w] <= rst_word(w);
        end else if (wr_en) begin
            words_q[wr_idx] <= wdata;
        end
    end

    assign rdata = words_q[rd_idx];

    // A written word holds the written value in the next cycle.
    assert_table_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words_q[$past(wr_idx)] == $past(wdata)));
endmodule

// File: rtl/irq_hub64.sv
// Top: APB register file, pending logic and processor request register.
// Zero wait states. Writes take effect on the access-phase edge, and reads
// return combinational data. Assumes a master that follows the APB protocol.
module irq_hub64
    import irq_hub_pkg::*;
#(
    parameter int                 ADDR_W     = 12,
    parameter logic [NUM_SRC-1:0] PULSE_MASK = 64'hFFFF_FFFF_0000_0000
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               cpu_irq
);
    localparam int WA_W = ADDR_W - 2;

    logic               master_en_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] flag_w;
    logic [NUM_SRC-1:0] state_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] clr_keep_w;
    logic               clr_we_w;
    logic               cpu_irq_q;
    logic [31:0]        tbl_rdata;

    logic               wr_acc;
    logic               rd_acc;
    logic               aligned;
    logic [WA_W-1:0]    waddr;
    logic               tbl_hit;
    logic               reg_hit;

    // Bus decode: aligned word address and access qualifiers.
    assign aligned = (paddr[1:0] == 2'b00);
    assign waddr   = paddr[ADDR_W-1:2];
    assign wr_acc  = psel & penable & pwrite & aligned;
    assign rd_acc  = psel & ~pwrite;
    assign tbl_hit = aligned && (paddr[ADDR_W-1:6] == (ADDR_W-6)'(OFF_TBL >> 6));

    function automatic logic is_off(input logic [WA_W-1:0] a, input logic [11:0] off);
        return a == WA_W'(off >> 2);
    endfunction

    assign reg_hit = aligned && (is_off(waddr, OFF_CTRL) || is_off(waddr, OFF_FLAG_LO) ||
                     is_off(waddr, OFF_FLAG_HI) || is_off(waddr, OFF_EN_LO) ||
                     is_off(waddr, OFF_EN_HI) || is_off(waddr, OFF_PEND_LO) ||
                     is_off(waddr, OFF_PEND_HI) || tbl_hit);

    // Control and enable registers.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            master_en_q <= 1'b0;
            en_q        <= '0;
        end else if (wr_acc) begin
            if (is_off(waddr, OFF_CTRL))  master_en_q <= pwdata[MASTER_BIT];
            if (is_off(waddr, OFF_EN_LO)) en_q[WORD_W-1:0] <= pwdata;
            if (is_off(waddr, OFF_EN_HI)) en_q[NUM_SRC-1:WORD_W] <= pwdata;
        end
    end

    // Flag clear request: a 0 in write data clears the matching flag.
    always_comb begin
        clr_we_w   = 1'b0;
        clr_keep_w = '1;
        if (wr_acc && is_off(waddr, OFF_FLAG_LO)) begin
            clr_we_w = 1'b1;
            clr_keep_w[WORD_W-1:0] = pwdata;
        end
        if (wr_acc && is_off(waddr, OFF_FLAG_HI)) begin
            clr_we_w = 1'b1;
            clr_keep_w[NUM_SRC-1:WORD_W] = pwdata;
        end
    end

    irq_src_stage #(
        .NUM_SRC    (NUM_SRC),
        .PULSE_MASK (PULSE_MASK)
    ) u_src (
        .clk       (pclk),
        .rst_n     (presetn),
        .src_in    (src_in),
        .clr_we    (clr_we_w),
        .clr_keep  (clr_keep_w),
        .flag_q    (flag_w),
        .src_state (state_w)
    );

    irq_chan_table #(
        .WORDS (TBL_WORDS),
        .IDX_W (TBL_IDX_W)
    ) u_tbl (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr_en  (wr_acc & tbl_hit),
        .wr_idx (paddr[2 +: TBL_IDX_W]),
        .wdata  (pwdata),
        .rd_idx (paddr[2 +: TBL_IDX_W]),
        .rdata  (tbl_rdata)
    );

    assign pend_w = en_q & state_w;

    // Processor request register, gated by the master enable.
    always_ff @(posedge pclk) begin
        if (!presetn) cpu_irq_q <= 1'b0;
        else          cpu_irq_q <= master_en_q & (|pend_w);
    end
    assign cpu_irq = cpu_irq_q;

    // Read data mux; unmapped and idle reads give zero.
    always_comb begin
        prdata = '0;
        if (rd_acc && aligned) begin
            if (tbl_hit)                       prdata = tbl_rdata;
            else if (is_off(waddr, OFF_CTRL))    prdata = {master_en_q, 31'd0};
            else if (is_off(waddr, OFF_FLAG_LO)) prdata = flag_w[WORD_W-1:0];
            else if (is_off(waddr, OFF_FLAG_HI)) prdata = flag_w[NUM_SRC-1:WORD_W];
            else if (is_off(waddr, OFF_EN_LO))   prdata = en_q[WORD_W-1:0];
            else if (is_off(waddr, OFF_EN_HI))   prdata = en_q[NUM_SRC-1:WORD_W];
            else if (is_off(waddr, OFF_PEND_LO)) prdata = pend_w[WORD_W-1:0];
            else if (is_off(waddr, OFF_PEND_HI)) prdata = pend_w[NUM_SRC-1:WORD_W];
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Request only while the master enable was set in the prior cycle.
    assert_irq_gated_R3: assert property (@(posedge pclk) disable iff (!presetn)
        cpu_irq |-> $past(master_en_q));

    // Any pending bit with the master enable set raises the request next cycle.
    assert_irq_follows_R9: assert property (@(posedge pclk) disable iff (!presetn)
        (master_en_q && (pend_w != '0)) |=> cpu_irq);

    // Reads outside the map return zero.
    assert_unmapped_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_acc && !reg_hit) |-> (prdata == 32'd0));

    // Reset leaves the request low in the following cycle.
    assert_reset_low_R1: assert property (@(posedge pclk)
        !presetn |=> !cpu_irq);
endmodule

// File: tb/tb_irq_hub64.sv
module tb_irq_hub64;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [63:0] src_in = '0;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 pclk = ~pclk;

    irq_hub64 dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .src_in(src_in), .cpu_irq(cpu_irq)
    );

    // Vector: {is_write, addr, data}; reads compare data.
    localparam int NV = 24;
    localparam logic [44:0] VECS [NV] = '{
        {1'b0, 12'h000, 32'h0000_0000},   // R1 control clear
        {1'b0, 12'h010, 32'h0000_0000},   // R1 enable low clear
        {1'b0, 12'h028, 32'h0000_0000},   // R1 enable high clear
        {1'b0, 12'h008, 32'h0000_0000},   // R1 flags low clear
        {1'b0, 12'h020, 32'h0000_0000},   // R1 flags high clear
        {1'b0, 12'h014, 32'h0000_0000},   // R7 pending low idle
        {1'b0, 12'h02C, 32'h0000_0000},   // R7 pending high idle
        {1'b0, 12'h040, 32'h0001_0203},   // R6 default word 0
        {1'b0, 12'h07C, 32'h3C3D_3E3F},   // R6 default word 15
        {1'b0, 12'h05C, 32'h1C1D_1E1F},   // R6 default word 7
        {1'b1, 12'h044, 32'hA55A_3C0F},   // R6 table write
        {1'b0, 12'h044, 32'hA55A_3C0F},   // R6 table readback
        {1'b1, 12'h028, 32'h1234_5678},   // R2 enable high write
        {1'b0, 12'h028, 32'h1234_5678},   // R2 enable high readback
        {1'b1, 12'h028, 32'h0000_0000},   // R2 restore
        {1'b1, 12'h004, 32'hFFFF_FFFF},   // R10 unmapped write
        {1'b0, 12'h004, 32'h0000_0000},   // R10 unmapped read
        {1'b0, 12'h081, 32'h0000_0000},   // R10 unaligned read
        {1'b1, 12'h000, 32'hFFFF_FFFF},   // R3 control write
        {1'b0, 12'h000, 32'h8000_0000},   // R3 only master bit kept
        {1'b1, 12'h000, 32'h7FFF_FFFF},   // R3 clear master
        {1'b0, 12'h000, 32'h0000_0000},   // R3 readback zero
        {1'b1, 12'h014, 32'hFFFF_FFFF},   // R7 pending write ignored
        {1'b0, 12'h014, 32'h0000_0000}    // R7 pending still zero
    };

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #1 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge pclk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        wait_n(4);
        chk("R1", "cpu_irq in reset", {31'd0, cpu_irq}, 32'd0);
        presetn = 1;
        wait_n(1);
        chk("R10", "pready/pslverr", {30'd0, pready, pslverr}, 32'd2);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v][44]) apb_wr(VECS[v][43:32], VECS[v][31:0]);
            else begin
                apb_rd(VECS[v][43:32], rd);
                chk("vec", $sformatf("vector %0d addr %h", v, VECS[v][43:32]), rd, VECS[v][31:0]);
            end
        end

        // R9 level source 3 through to cpu_irq with three edge latency.
        apb_wr(12'h010, 32'h0000_0008);
        apb_wr(12'h000, 32'h8000_0000);
        @(negedge pclk); src_in[3] = 1;
        wait_n(2);
        chk("R9", "cpu_irq after 2 edges", {31'd0, cpu_irq}, 32'd0);
        wait_n(1);
        chk("R9", "cpu_irq after 3 edges", {31'd0, cpu_irq}, 32'd1);
        apb_rd(12'h014, rd);
        chk("R7", "level pending", rd, 32'h0000_0008);

        // R3 master clear drops cpu_irq while pending stays.
        apb_wr(12'h000, 32'h0);
        wait_n(1);
        chk("R3", "cpu_irq master off", {31'd0, cpu_irq}, 32'd0);
        apb_rd(12'h014, rd);
        chk("R3", "pending with master off", rd, 32'h0000_0008);
        apb_wr(12'h000, 32'h8000_0000);

        // R8 level input low clears pending.
        @(negedge pclk); src_in[3] = 0;
        wait_n(3);
        apb_rd(12'h014, rd);
        chk("R8", "level pending dropped", rd, 32'h0);
        wait_n(1);
        chk("R8", "cpu_irq dropped", {31'd0, cpu_irq}, 32'd0);

        // R7 disabled level source not pending; level flag reads zero.
        @(negedge pclk); src_in[5] = 1;
        wait_n(4);
        apb_rd(12'h014, rd);
        chk("R7", "disabled source", rd, 32'h0);
        apb_rd(12'h008, rd);
        chk("R4", "level flag bits", rd, 32'h0);
        chk("R7", "cpu_irq disabled src", {31'd0, cpu_irq}, 32'd0);
        @(negedge pclk); src_in[5] = 0;

        // R4 pulse on source 32 captured and held.
        apb_wr(12'h028, 32'h0000_0001);
        @(negedge pclk); src_in[32] = 1;
        @(negedge pclk); src_in[32] = 0;
        wait_n(4);
        apb_rd(12'h020, rd);
        chk("R4", "flag held", rd, 32'h0000_0001);
        apb_rd(12'h02C, rd);
        chk("R7", "pulse pending", rd, 32'h0000_0001);
        chk("R9", "cpu_irq pulse", {31'd0, cpu_irq}, 32'd1);

        // R5 write of 1 keeps, write of 0 clears.
        apb_wr(12'h020, 32'hFFFF_FFFF);
        apb_rd(12'h020, rd);
        chk("R5", "flag kept on 1", rd, 32'h0000_0001);
        apb_wr(12'h020, 32'hFFFF_FFFE);
        apb_rd(12'h02C, rd);
        chk("R8", "pending after clear", rd, 32'h0);
        apb_rd(12'h020, rd);
        chk("R5", "flag cleared", rd, 32'h0);
        chk("R8", "cpu_irq after clear", {31'd0, cpu_irq}, 32'd0);

        // R4 pulse on disabled source 40 still captured; enabling shows it.
        @(negedge pclk); src_in[40] = 1;
        @(negedge pclk); src_in[40] = 0;
        wait_n(4);
        apb_rd(12'h02C, rd);
        chk("R7", "disabled pulse pending", rd, 32'h0);
        apb_rd(12'h020, rd);
        chk("R4", "disabled pulse flag", rd, 32'h0000_0100);
        apb_wr(12'h028, 32'h0000_0101);
        apb_rd(12'h02C, rd);
        chk("R7", "pulse pending after enable", rd, 32'h0000_0100);
        apb_wr(12'h028, 32'h0000_0001);
        apb_rd(12'h02C, rd);
        chk("R8", "pending after disable", rd, 32'h0);

        // R1 reset with a live level source.
        apb_wr(12'h010, 32'h0000_0010);
        @(negedge pclk); src_in[4] = 1;
        wait_n(5);
        chk("R9", "cpu_irq before reset", {31'd0, cpu_irq}, 32'd1);
        presetn = 0;
        wait_n(3);
        chk("R1", "cpu_irq held in reset", {31'd0, cpu_irq}, 32'd0);
        presetn = 1;
        apb_rd(12'h010, rd);
        chk("R1", "enable low after reset", rd, 32'h0);
        apb_rd(12'h020, rd);
        chk("R1", "flags after reset", rd, 32'h0);
        apb_rd(12'h044, rd);
        chk("R6", "table restored", rd, 32'h0405_0607);
        apb_rd(12'h000, rd);
        chk("R1", "control after reset", rd, 32'h0);
        chk("R1", "cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule